// File: doc/BRIEF.md
# Scatter Segment to PRD Splitter

This block turns a list of scatter-gather segments into physical region descriptor (PRD) entries that a bus-master disk DMA engine can walk. Each segment is a 32-bit bus address and a 32-bit byte length. It arrives on a valid/ready channel, and the final segment of a request carries a marker. The block cuts each segment so that no descriptor crosses a 64 KiB address boundary. Each descriptor is sent on a second valid/ready channel as an address word and a control word.

A request can fail in two ways. It can need more descriptors than the table holds, or it can hold no bytes at all. In either case a one-cycle completion pulse flags the error and reports a count of zero, and the caller then moves the data by programmed I/O. Some hosts read a count field of zero as zero bytes rather than 64 KiB. For those hosts, a mode input makes the block break every full 64 KiB piece into two halves.

Top module: `prd_splitter`

## Requirements
- R1: The byte length of each descriptor is the smaller of two values: the bytes left in the segment, and 0x10000 minus address bits [15:0]. No descriptor spans a 64 KiB boundary.
- R2: Descriptors of a request appear in order. Each address equals the previous address plus the previous length, and each segment restarts at its own base address.
- R3: Control bits [15:0] hold the low 16 bits of the byte length, so a 64 KiB descriptor carries 0x0000. Control bits [30:16] are zero.
- R4: With halve_full high, a descriptor that would be 64 KiB is sent as two descriptors of 0x8000 bytes: one at the original address and one at that address plus 0x8000. Both count toward the table limit, and no control word then has a zero length field.
- R5: Control bit 31 is set on the final descriptor of a successful request and on no other descriptor.
- R6: If a request needs more than MAX_ENTRIES descriptors, the completion pulse shows done_overflow=1 and done_count=0. No descriptor of that request carries bit 31, and the rest of the request's segments are consumed and discarded.
- R7: A request whose segments all have zero length produces no descriptors and completes with done_empty=1 and done_count=0.
- R8: Exactly one done_valid pulse occurs per request, after its marked segment is accepted. On success, done_count equals the number of descriptors.
- R9: Under output back-pressure a held descriptor keeps its value, and every descriptor is delivered exactly once.
- R10: After reset, prd_valid and done_valid are low and seg_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halve_full | input | 1 | Split 64 KiB descriptors into two 32 KiB halves |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment accepted this cycle when high with seg_valid |
| seg_addr | input | 32 | Segment bus address |
| seg_len | input | 32 | Segment byte length |
| seg_last | input | 1 | Segment closes the request |
| prd_valid | output | 1 | Descriptor offered |
| prd_ready | input | 1 | Descriptor taken |
| prd_addr | output | 32 | Descriptor address word |
| prd_ctrl | output | 32 | Descriptor control word: [15:0] length, [31] end of table |
| done_valid | output | 1 | One-cycle completion pulse |
| done_count | output | $clog2(MAX_ENTRIES+1) | Descriptors built, zero on error |
| done_overflow | output | 1 | Table limit exceeded |
| done_empty | output | 1 | Request produced nothing |

## Verification
The assertions check on every cycle that no offered descriptor crosses a 64 KiB boundary, that a stalled descriptor holds still, that the reserved control bits stay zero, and that halving mode never shows a zero length field. The bench's scenarios are needed for the rest: the exact sequence of addresses, the end-of-table flag on only the final entry, and the descriptor totals. The same goes for the overflow and empty outcomes and for the absence of drops or duplicates under random back-pressure. For these the bench compares each request against an arithmetic model, sweeping start offsets and lengths around the 32 KiB and 64 KiB edges in both modes.

// File: rtl/prd_splitter.sv
module prd_splitter #(
  parameter int MAX_ENTRIES = 256,
  localparam int CW = $clog2(MAX_ENTRIES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          halve_full,
  input  logic          seg_valid,
  output logic          seg_ready,
  input  logic [31:0]   seg_addr,
  input  logic [31:0]   seg_len,
  input  logic          seg_last,
  output logic          prd_valid,
  input  logic          prd_ready,
  output logic [31:0]   prd_addr,
  output logic [31:0]   prd_ctrl,
  output logic          done_valid,
  output logic [CW-1:0] done_count,
  output logic          done_overflow,
  output logic          done_empty
);

  logic          have_seg, seg_end, fin, ovf;
  logic [31:0]   cur_addr, cur_len;
  logic          pend_v;
  logic [31:0]   pend_addr;
  logic [15:0]   pend_len;
  logic          out_v;
  logic [31:0]   out_addr, out_ctrl;
  logic [CW-1:0] cnt;
  logic [16:0]   room, chunk;
  logic          out_free, gen, full, seg_fire, seg_done, finish, push;

  assign room = 17'h10000 - {1'b0, cur_addr[15:0]};

  always_comb begin
    chunk = (cur_len < {15'd0, room}) ? cur_len[16:0] : room;
    if (halve_full && chunk == 17'h10000) chunk = 17'h08000;
  end

  assign out_free  = !out_v || prd_ready;
  assign gen       = have_seg && (!pend_v || out_free);
  assign full      = (cnt == CW'(MAX_ENTRIES));
  assign seg_done  = ({15'd0, chunk} == cur_len);
  assign finish    = fin && (!pend_v || out_free);
  assign push      = pend_v && out_free && ((gen && !full) || (finish && !ovf));
  assign seg_ready = !have_seg && !fin;
  assign seg_fire  = seg_valid && seg_ready;

  assign prd_valid = out_v;
  assign prd_addr  = out_addr;
  assign prd_ctrl  = out_ctrl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_seg <= 1'b0;
      seg_end  <= 1'b0;
      fin      <= 1'b0;
      ovf      <= 1'b0;
      cur_addr <= '0;
      cur_len  <= '0;
      cnt      <= '0;
      pend_v   <= 1'b0;
      pend_addr <= '0;
      pend_len <= '0;
    end else begin
      if (seg_fire) begin
        seg_end <= seg_last;
        if (seg_len != 32'd0 && !ovf) begin
          have_seg <= 1'b1;
          cur_addr <= seg_addr;
          cur_len  <= seg_len;
        end else if (seg_last) begin
          fin <= 1'b1;
        end
      end
      if (gen) begin
        if (full) begin
          ovf      <= 1'b1;
          have_seg <= 1'b0;
          pend_v   <= 1'b0;
          if (seg_end) fin <= 1'b1;
        end else begin
          pend_v    <= 1'b1;
          pend_addr <= cur_addr;
          pend_len  <= chunk[15:0];
          cnt       <= cnt + CW'(1);
          cur_addr  <= cur_addr + {15'd0, chunk};
          cur_len   <= cur_len - {15'd0, chunk};
          if (seg_done) begin
            have_seg <= 1'b0;
            if (seg_end) fin <= 1'b1;
          end
        end
      end
      if (finish) begin
        fin    <= 1'b0;
        ovf    <= 1'b0;
        cnt    <= '0;
        pend_v <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_v    <= 1'b0;
      out_addr <= '0;
      out_ctrl <= '0;
    end else if (push) begin
      out_v    <= 1'b1;
      out_addr <= pend_addr;
      out_ctrl <= {finish, 15'd0, pend_len};
    end else if (prd_ready) begin
      out_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_valid    <= 1'b0;
      done_count    <= '0;
      done_overflow <= 1'b0;
      done_empty    <= 1'b0;
    end else begin
      done_valid <= finish;
      if (finish) begin
        done_count    <= ovf ? '0 : cnt;
        done_overflow <= ovf;
        done_empty    <= !ovf && (cnt == '0);
      end
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prd_valid && !prd_ready |=> prd_valid && $stable(prd_addr) && $stable(prd_ctrl));

  // R1
  boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prd_valid |-> ({2'b0, prd_addr[15:0]} +
      ((prd_ctrl[15:0] == 16'd0) ? 18'h10000 : {2'b0, prd_ctrl[15:0]})) <= 18'h10000);

  // R3
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prd_valid |-> prd_ctrl[30:16] == 15'd0);

  // R4
  halve_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prd_valid && halve_full |-> prd_ctrl[15:0] != 16'd0);

  // R6
  ovf_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && done_overflow |-> done_count == '0 && !done_empty);

  // R8
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> done_count <= CW'(MAX_ENTRIES));

endmodule

// File: tb/prd_splitter_test.sv
module prd_splitter_test;
  localparam int MAXE = 8;
  localparam int CW = $clog2(MAXE + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halve_full = 1'b0;
  logic seg_valid = 1'b0;
  logic seg_ready;
  logic [31:0] seg_addr = '0, seg_len = '0;
  logic seg_last = 1'b0;
  logic prd_valid;
  logic prd_ready = 1'b0;
  logic [31:0] prd_addr, prd_ctrl;
  logic done_valid, done_overflow, done_empty;
  logic [CW-1:0] done_count;

  always #4 clk = ~clk;

  prd_splitter #(.MAX_ENTRIES(MAXE)) uut (.*);

  int tests = 0, fails = 0;
  logic [31:0] sa [16], sl [16];
  int sn;
  logic [31:0] exp_a [32], exp_c [32];
  int expn;
  bit exp_ovf;
  logic [31:0] got_a [32], got_c [32];
  int ng, dn;
  logic [CW-1:0] d_cnt;
  bit d_ovf, d_emp;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic void model(input bit hm);
    logic [31:0] a, l, room, c;
    expn = 0; exp_ovf = 0;
    for (int i = 0; i < sn; i++) begin
      a = sa[i]; l = sl[i];
      while (l != 0 && !exp_ovf) begin
        room = 32'h10000 - {16'h0, a[15:0]};
        c = (l < room) ? l : room;
        if (hm && c == 32'h10000) c = 32'h8000;
        if (expn == MAXE) exp_ovf = 1;
        else begin
          exp_a[expn] = a; exp_c[expn] = c; expn++;
          a += c; l -= c;
        end
      end
    end
  endfunction

  task automatic drive_segs();
    for (int i = 0; i < sn; i++) begin
      @(negedge clk);
      seg_valid = 1; seg_addr = sa[i]; seg_len = sl[i]; seg_last = (i == sn - 1);
      #1;
      while (!seg_ready) begin @(negedge clk); #1; end
      @(posedge clk);
    end
    @(negedge clk);
    seg_valid = 0; seg_last = 0;
  endtask

  task automatic collect();
    int after = -1;
    int cyc = 0;
    ng = 0; dn = 0;
    while (after < 8 && cyc < 5000) begin
      @(negedge clk); cyc++;
      prd_ready = (after >= 0) ? 1'b1 : ($urandom % 4 != 0);
      #1;
      if (prd_valid && prd_ready) begin
        if (ng < 32) begin got_a[ng] = prd_addr; got_c[ng] = prd_ctrl; end
        ng++;
      end
      if (done_valid) begin
        dn++; d_cnt = done_count; d_ovf = done_overflow; d_emp = done_empty; after = 0;
      end else if (after >= 0) after++;
    end
  endtask

  task automatic run(input bit hm);
    halve_full = hm;
    model(hm);
    fork
      drive_segs();
      collect();
    join
    chk(dn == 1, "R8 one done pulse", dn, 1);
    if (exp_ovf) begin
      chk(d_ovf && !d_emp, "R6 overflow flag", {d_ovf, d_emp}, 2);
      chk(d_cnt == 0, "R6 overflow count", d_cnt, 0);
      chk(ng <= MAXE, "R6 entries bounded", ng, MAXE);
      for (int k = 0; k < ng && k < 32; k++)
        chk(!got_c[k][31], "R6 no end flag", got_c[k], 0);
    end else if (expn == 0) begin
      chk(d_emp && !d_ovf, "R7 empty flag", {d_ovf, d_emp}, 1);
      chk(d_cnt == 0 && ng == 0, "R7 nothing built", ng, 0);
    end else begin
      chk(!d_ovf && !d_emp, "R8 no error", {d_ovf, d_emp}, 0);
      chk(d_cnt == expn, "R8 done count", d_cnt, expn);
      chk(ng == expn, "R9 delivered once", ng, expn);
      for (int k = 0; k < expn && k < ng; k++) begin
        chk(got_a[k] == exp_a[k], "R2 address", got_a[k], exp_a[k]);
        chk(got_c[k][15:0] == exp_c[k][15:0], "R1 R3 length", got_c[k][15:0], exp_c[k][15:0]);
        chk(got_c[k][31] == (k == expn - 1), "R5 end flag", got_c[k][31], (k == expn - 1));
        if (hm) chk(got_c[k][15:0] != 0, "R4 no zero length", got_c[k][15:0], 16'h8000);
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] offs [5], lens [5];
    offs = '{32'h0, 32'h1, 32'h7FFF, 32'h8000, 32'hFFFF};
    lens = '{32'h1, 32'h8000, 32'h10000, 32'h10001, 32'h20000};
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R10
    chk(!prd_valid && !done_valid && seg_ready, "R10 reset state",
        {prd_valid, done_valid, seg_ready}, 3'b001);

    sn = 1; sa[0] = 32'h1234_0000; sl[0] = 32'h100; run(0);
    sn = 1; sa[0] = 32'h0000_FFF0; sl[0] = 32'h20; run(0);           // R1 crossing
    sn = 1; sa[0] = 32'h0005_0000; sl[0] = 32'h10000; run(0);        // R3 full
    sn = 1; sa[0] = 32'h0005_0000; sl[0] = 32'h10000; run(1);        // R4 halve
    sn = 3; sa[0] = 32'h100; sl[0] = 32'h40; sa[1] = 32'h9000; sl[1] = 0;
    sa[2] = 32'h3_FF00; sl[2] = 32'h300; run(0);                     // R2 multi
    sn = 1; sa[0] = 32'h4000; sl[0] = 0; run(0);                     // R7 empty
    sn = 2; sa[0] = 32'h10; sl[0] = 0; sa[1] = 32'h20; sl[1] = 0; run(1); // R7
    sn = 1; sa[0] = 32'h0010_0000; sl[0] = 32'h90000; run(0);        // R6 overflow
    sn = 3; sa[0] = 32'h0010_0000; sl[0] = 32'h50000; sa[1] = 32'h0020_0000;
    sl[1] = 32'h50000; sa[2] = 32'h40; sl[2] = 32'h10; run(0);       // R6 drop rest
    sn = 1; sa[0] = 32'h0010_0000; sl[0] = 32'h80000; run(0);        // exactly MAXE
    sn = 1; sa[0] = 32'h0010_0000; sl[0] = 32'h40000; run(1);        // R4 at limit
    sn = 1; sa[0] = 32'h0010_0000; sl[0] = 32'h48000; run(1);        // R4 overflow
    for (int h = 0; h < 2; h++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++) begin
          sn = 1; sa[0] = 32'h0012_0000 + offs[i]; sl[0] = lens[j];
          run(h[0]);
        end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule